// File: doc/BRIEF.md
# Composite-Field AES Substitution Unit

This unit produces the AES byte-substitution result for one byte. Both the input and the output byte are held in a tower-field representation: the byte is split into two 4-bit halves over GF(2^4), joined by a degree-2 extension. Keeping the data in that form lets the multiplicative inverse be built from 4-bit operations only. These are a squarer, a constant multiplier, three general 4-bit multipliers, XOR adders and a 16-entry 4-bit inverse. The AES affine step follows, with its matrix and constant converted into the same representation.

The unit is meant to sit inside a datapath that changes basis once, on entry to the cipher, and once more on exit, so that every round stays in tower form. It is purely combinational, with no clock, no register and no reset. The basis-change matrix is a parameter. The inverse basis change, the converted affine matrix and the converted affine constant are all derived from it during elaboration.

Top module: `cf_sbox`

## Requirements
- R1: The 4-bit subfield uses the reduction polynomial y^4+y+1. Bit i of a nibble is the coefficient of w^i, where w is a root of that polynomial. A byte is a0 + b·a1: bits [3:0] hold a0 and bits [7:4] hold a1. The extension element b satisfies b^2 + b + L = 0, with L = w^14 = 4'h9.
- R2: The standard-to-tower map T is given as eight row strings, listed first to last: 10100000, 10101100, 11010010, 01110000, 11000110, 01010010, 00001010, 11011101. Row string r produces output bit 7-r. Its leftmost character multiplies input bit 7. T maps 1 to 1, and it maps every product taken modulo x^8+x^4+x^3+x+1 to the corresponding tower-field product.
- R3: For every nonzero input x, the inverse stage forms D = a0(a0+a1) + L·a1^2, then b0 = (a0+a1)·D^-1 and b1 = a1·D^-1. The value b0 + b·b1 multiplied by x gives 1.
- R4: The 4-bit inverse returns 0 for input 0. D is zero only when the whole input byte is zero. Input 8'h00 therefore yields T·8'h63, which is 8'h63 in the standard basis.
- R5: The affine stage applies T·A·T^-1 and then adds T·8'h63. A is the AES matrix whose output bit i is the XOR of input bits i, i+4, i+5, i+6 and i+7 (mod 8). Seen in the standard basis, the output equals A·v XOR 8'h63, where v is the inverse found by the previous stage.
- R6: For all 256 standard bytes s, T^-1 · cf_sbox(T·s) equals the AES substitution of s. Sample values: 8'h00→8'h63, 8'h01→8'h7C, 8'h53→8'hED, 8'h80→8'hCD, 8'hFF→8'h16.
- R7: The output depends only on the present input. A change on comp_in shows on comp_out with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| comp_in | input | 8 | Byte in tower-field form: a1 in [7:4], a0 in [3:0] |
| comp_out | output | 8 | Substituted byte, in the same tower-field form |

## Verification
The in-design checks assume that comp_in carries a settled two-state value. They also assume that the matrix parameter is invertible and is a true field isomorphism, since every check converts back through T^-1 or multiplies in the tower field. The stimulus uses only the default matrix and polynomials. It changes the input between clock edges and reads the output only after the combinational paths have settled. It visits each of the 256 byte values, and it confirms the matrix convention in the bench model before any result from the unit is trusted.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;
  // 8x8 matrix over GF(2): slice [8*k +: 8] is the row driving output bit k,
  // and bit j of that row multiplies input bit j.
  typedef logic [BYTE_W*BYTE_W-1:0] bmat_t;

  localparam bmat_t T_DEFAULT = {8'b10100000, 8'b10101100, 8'b11010010, 8'b01110000,
                                 8'b11000110, 8'b01010010, 8'b00001010, 8'b11011101};

  function automatic nib_t gf16_mul_f(nib_t a, nib_t b, logic [4:0] poly);
    logic [7:0] p;
    p = 8'h00;
    for (int i = 0; i < NIB_W; i++)
      if (b[i]) p = p ^ ({4'h0, a} << i);
    for (int k = 6; k >= 4; k--)
      if (p[k]) p = p ^ ({3'b000, poly} << (k - 4));
    return p[3:0];
  endfunction

  // Columns of a GF(2)-linear 4-bit map: either squaring or times a constant.
  function automatic logic [15:0] gf16_lin_cols(bit square, nib_t k, logic [4:0] poly);
    logic [15:0] c;
    nib_t e;
    c = 16'h0000;
    for (int j = 0; j < NIB_W; j++) begin
      e = nib_t'(1) << j;
      c[4*j +: 4] = square ? gf16_mul_f(e, e, poly) : gf16_mul_f(e, k, poly);
    end
    return c;
  endfunction

  function automatic logic [63:0] gf16_inv_table(logic [4:0] poly);
    logic [63:0] t;
    t = 64'h0;
    for (int x = 1; x < 16; x++)
      for (int y = 1; y < 16; y++)
        if (gf16_mul_f(nib_t'(x), nib_t'(y), poly) == 4'h1) t[4*x +: 4] = nib_t'(y);
    return t;
  endfunction

  function automatic byte_t cf_mul_f(byte_t x, byte_t y, nib_t lam, logic [4:0] poly);
    nib_t hh, lo, hi;
    hh = gf16_mul_f(x[7:4], y[7:4], poly);
    lo = gf16_mul_f(x[3:0], y[3:0], poly) ^ gf16_mul_f(hh, lam, poly);
    hi = gf16_mul_f(x[3:0], y[7:4], poly) ^ gf16_mul_f(x[7:4], y[3:0], poly) ^ hh;
    return {hi, lo};
  endfunction

  function automatic byte_t bmat_apply(bmat_t m, byte_t x);
    byte_t y;
    for (int k = 0; k < BYTE_W; k++) y[k] = ^(m[8*k +: 8] & x);
    return y;
  endfunction

  function automatic bmat_t bmat_mul(bmat_t a, bmat_t b);
    bmat_t r;
    byte_t row;
    for (int k = 0; k < BYTE_W; k++) begin
      row = 8'h00;
      for (int i = 0; i < BYTE_W; i++)
        if (a[8*k + i]) row = row ^ b[8*i +: 8];
      r[8*k +: 8] = row;
    end
    return r;
  endfunction

  // Gauss-Jordan elimination over GF(2).
  function automatic bmat_t bmat_inv(bmat_t m);
    byte_t a [BYTE_W];
    byte_t r [BYTE_W];
    byte_t tmp;
    bmat_t res;
    int p;
    for (int k = 0; k < BYTE_W; k++) begin
      a[k] = m[8*k +: 8];
      r[k] = byte_t'(1) << k;
    end
    for (int c = 0; c < BYTE_W; c++) begin
      p = -1;
      for (int k = c; k < BYTE_W; k++)
        if (p < 0 && a[k][c]) p = k;
      if (p >= 0) begin
        tmp = a[c]; a[c] = a[p]; a[p] = tmp;
        tmp = r[c]; r[c] = r[p]; r[p] = tmp;
        for (int k = 0; k < BYTE_W; k++)
          if (k != c && a[k][c]) begin
            a[k] = a[k] ^ a[c];
            r[k] = r[k] ^ r[c];
          end
      end
    end
    for (int k = 0; k < BYTE_W; k++) res[8*k +: 8] = r[k];
    return res;
  endfunction

  function automatic bmat_t aes_affine_mat();
    bmat_t m;
    byte_t row;
    for (int i = 0; i < BYTE_W; i++) begin
      row = 8'h00;
      row[i] = 1'b1;
      for (int s = 4; s < 8; s++) row[(i + s) % 8] = 1'b1;
      m[8*i +: 8] = row;
    end
    return m;
  endfunction

endpackage

// File: rtl/gf16_mul.sv
module gf16_mul #(
  parameter logic [4:0] POLY = 5'b10011
) (
  input  logic [3:0] a,
  input  logic [3:0] b,
  output logic [3:0] p
);
  logic [6:0] pp [4];

  for (genvar g = 0; g < 4; g++) begin : g_pp
    assign pp[g] = b[g] ? ({3'b000, a} << g) : 7'd0;
  end

  always_comb begin
    logic [6:0] acc;
    acc = 7'd0;
    for (int i = 0; i < 4; i++) acc = acc ^ pp[i];
    for (int k = 6; k >= 4; k--)
      if (acc[k]) acc = acc ^ ({2'b00, POLY} << (k - 4));
    p = acc[3:0];
  end
endmodule

// File: rtl/gf16_lin.sv
module gf16_lin #(
  parameter bit         SQUARE = 1'b0,
  parameter logic [3:0] K      = 4'h1,
  parameter logic [4:0] POLY   = 5'b10011
) (
  input  logic [3:0] x,
  output logic [3:0] y
);
  localparam logic [15:0] COLS = cfs_pkg::gf16_lin_cols(SQUARE, K, POLY);

  for (genvar b = 0; b < 4; b++) begin : g_bit
    assign y[b] = ^({COLS[12+b], COLS[8+b], COLS[4+b], COLS[b]} & x);
  end
endmodule

// File: rtl/gf16_inv.sv
module gf16_inv #(
  parameter logic [4:0] POLY = 5'b10011
) (
  input  logic [3:0] x,
  output logic [3:0] y
);
  localparam logic [63:0] TAB = cfs_pkg::gf16_inv_table(POLY);

  always_comb begin
    y = TAB[{x, 2'b00} +: 4];
    AST_SUB_INVERSE: assert ((x == 4'h0) ? (y == 4'h0)
                             : (cfs_pkg::gf16_mul_f(x, y, POLY) == 4'h1))
      else $error("subfield inverse wrong for %h", x); // R4
  end
endmodule

// File: rtl/cf_inverter.sv
module cf_inverter #(
  parameter logic [4:0] POLY   = 5'b10011,
  parameter logic [3:0] LAMBDA = 4'h9
) (
  input  logic [7:0] x,
  output logic [7:0] y
);
  logic [3:0] a0, a1, s, a1_sq, l_sq, prod0, delta, delta_inv, b0, b1;

  assign a0 = x[3:0];
  assign a1 = x[7:4];
  assign s  = a0 ^ a1;

  gf16_lin #(.SQUARE(1'b1), .K(4'h1), .POLY(POLY)) u_sq (.x(a1), .y(a1_sq));
  gf16_lin #(.SQUARE(1'b0), .K(LAMBDA), .POLY(POLY)) u_lam (.x(a1_sq), .y(l_sq));
  gf16_mul #(.POLY(POLY)) u_m0 (.a(a0), .b(s), .p(prod0));

  assign delta = prod0 ^ l_sq;

  gf16_inv #(.POLY(POLY)) u_dinv (.x(delta), .y(delta_inv));
  gf16_mul #(.POLY(POLY)) u_m1 (.a(s), .b(delta_inv), .p(b0));
  gf16_mul #(.POLY(POLY)) u_m2 (.a(a1), .b(delta_inv), .p(b1));

  assign y = {b1, b0};

  always_comb begin
    AST_DELTA_ZERO: assert ((delta == 4'h0) == (x == 8'h00))
      else $error("norm zero mismatch for %h", x); // R4
    AST_COMP_INVERSE: assert ((x == 8'h00) ? (y == 8'h00)
                              : (cfs_pkg::cf_mul_f(x, y, LAMBDA, POLY) == 8'h01))
      else $error("tower inverse wrong for %h", x); // R3
  end
endmodule

// File: rtl/cf_lin_map.sv
module cf_lin_map #(
  parameter cfs_pkg::bmat_t MAT    = cfs_pkg::T_DEFAULT,
  parameter logic [7:0]     OFFSET = 8'h00
) (
  input  logic [7:0] x,
  output logic [7:0] y
);
  for (genvar k = 0; k < 8; k++) begin : g_row
    if (OFFSET[k]) begin : g_inv
      assign y[k] = ~(^(MAT[8*k +: 8] & x));
    end else begin : g_pass
      assign y[k] = ^(MAT[8*k +: 8] & x);
    end
  end
endmodule

// File: rtl/cf_affine.sv
module cf_affine #(
  parameter cfs_pkg::bmat_t T_MAT = cfs_pkg::T_DEFAULT,
  parameter logic [7:0]     AFF_C = 8'h63
) (
  input  logic [7:0] x,
  output logic [7:0] y
);
  localparam cfs_pkg::bmat_t T_INV  = cfs_pkg::bmat_inv(T_MAT);
  localparam cfs_pkg::bmat_t A_STD  = cfs_pkg::aes_affine_mat();
  localparam cfs_pkg::bmat_t A_COMP = cfs_pkg::bmat_mul(cfs_pkg::bmat_mul(T_MAT, A_STD), T_INV);
  localparam logic [7:0]     C_COMP = cfs_pkg::bmat_apply(T_MAT, AFF_C);

  cf_lin_map #(.MAT(A_COMP), .OFFSET(C_COMP)) u_map (.x(x), .y(y));

  always_comb begin
    AST_AFFINE_STD: assert (cfs_pkg::bmat_apply(T_INV, y) ==
                            (cfs_pkg::bmat_apply(A_STD, cfs_pkg::bmat_apply(T_INV, x)) ^ AFF_C))
      else $error("affine step disagrees in standard basis for %h", x); // R5
  end
endmodule

// File: rtl/cf_sbox.sv
module cf_sbox #(
  parameter logic [4:0]     SUB_POLY = 5'b10011,
  parameter logic [3:0]     LAMBDA   = 4'h9,
  parameter cfs_pkg::bmat_t T_MAT    = cfs_pkg::T_DEFAULT,
  parameter logic [7:0]     AFF_C    = 8'h63
) (
  input  logic [7:0] comp_in,
  output logic [7:0] comp_out
);
  localparam logic [7:0] ZERO_OUT = cfs_pkg::bmat_apply(T_MAT, AFF_C);

  logic [7:0] inv_w;

  cf_inverter #(.POLY(SUB_POLY), .LAMBDA(LAMBDA)) u_inv (.x(comp_in), .y(inv_w));
  cf_affine   #(.T_MAT(T_MAT), .AFF_C(AFF_C))     u_aff (.x(inv_w), .y(comp_out));

  always_comb begin
    if (comp_in == 8'h00) begin
      AST_ZERO_MAP: assert (comp_out == ZERO_OUT)
        else $error("zero input gave %h", comp_out); // R4
    end
  end
endmodule

// File: tb/cf_sbox_test.sv
`timescale 1ns/1ps
module cf_sbox_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] comp_in = 8'h00;
  logic [7:0] comp_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] t_back [256];

  // R2: row strings, first listed row in the top byte (drives output bit 7)
  localparam logic [63:0] ROWS = {8'b10100000, 8'b10101100, 8'b11010010, 8'b01110000,
                                  8'b11000110, 8'b01010010, 8'b00001010, 8'b11011101};

  always #2 clk = ~clk;

  cf_sbox uut (.comp_in(comp_in), .comp_out(comp_out));

  function automatic logic [7:0] t_fwd(logic [7:0] x);
    logic [7:0] y;
    for (int k = 0; k < 8; k++) y[k] = ^(ROWS[8*k +: 8] & x);
    return y;
  endfunction

  function automatic logic [3:0] n_mul(logic [3:0] a, logic [3:0] b);
    logic [3:0] r, s;
    r = 4'h0; s = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) r = r ^ s;
      s = {s[2:0], 1'b0} ^ (s[3] ? 4'h3 : 4'h0);
    end
    return r;
  endfunction

  function automatic logic [7:0] c_mul(logic [7:0] x, logic [7:0] y);
    logic [3:0] top;
    top = n_mul(x[7:4], y[7:4]);
    return {n_mul(x[3:0], y[7:4]) ^ n_mul(x[7:4], y[3:0]) ^ top,
            n_mul(x[3:0], y[3:0]) ^ n_mul(top, 4'h9)};
  endfunction

  function automatic logic [7:0] s_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r, s;
    r = 8'h00; s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ s;
      s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1B : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] ref_sbox(logic [7:0] x);
    logic [7:0] v;
    v = 8'h00;
    for (int y = 1; y < 256; y++)
      if (s_mul(x, 8'(y)) == 8'h01) v = 8'(y);
    return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4) ^ 8'h63;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive_std(logic [7:0] s, output logic [7:0] res);
    @(posedge clk);
    comp_in <= t_fwd(s);
    @(negedge clk);
    res = t_back[comp_out];
  endtask

  task automatic t_basis();
    int bad;
    bad = 0;
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        if (t_fwd(s_mul(8'(x), 8'(y))) != c_mul(t_fwd(8'(x)), t_fwd(8'(y)))) bad++;
    check("R2 T maps products to tower products (mismatch count)", 8'(bad), 8'h00);
    check("R1 T maps 1 to tower one", t_fwd(8'h01), 8'h01);
    check("R1 w^14 is the inverse of w", n_mul(4'h9, 4'h2), 4'h1);
  endtask

  task automatic t_reset_zero();
    logic [7:0] r;
    check("R4 output while held in reset with zero input", t_back[comp_out], 8'h63);
    drive_std(8'h00, r);
    check("R4 zero byte maps to 63", r, 8'h63);
    check("R4 zero byte raw tower output", comp_out, t_fwd(8'h63));
  endtask

  task automatic t_known();
    logic [7:0] r;
    drive_std(8'h01, r); check("R6 vector 01", r, 8'h7C);
    drive_std(8'h53, r); check("R6 vector 53", r, 8'hED);
    drive_std(8'h80, r); check("R6 vector 80", r, 8'hCD);
    drive_std(8'hFF, r); check("R6 vector FF", r, 8'h16);
  endtask

  task automatic t_sweep();
    logic [7:0] r;
    for (int s = 0; s < 256; s++) begin
      drive_std(8'(s), r);
      check("R6 full sweep", r, ref_sbox(8'(s)));
    end
  endtask

  task automatic t_inverse();
    logic [7:0] r, v;
    for (int s = 1; s < 256; s++) begin
      drive_std(8'(s), r);
      v = rotl(r, 1) ^ rotl(r, 3) ^ rotl(r, 6) ^ 8'h05; // undo affine (R5)
      check("R3 recovered inverse times input", s_mul(8'(s), v), 8'h01);
    end
  endtask

  task automatic t_comb();
    @(posedge clk);
    #0.5 comp_in = t_fwd(8'h10);
    #0.4 check("R7 follows input without clock edge (10)", t_back[comp_out], 8'hCA);
    comp_in = t_fwd(8'hC9);
    #0.4 check("R7 follows input without clock edge (C9)", t_back[comp_out], 8'hDD);
  endtask

  initial begin
    for (int s = 0; s < 256; s++) t_back[t_fwd(8'(s))] = 8'(s);
    repeat (4) @(posedge clk);
    #1 t_reset_zero();
    rst <= 1'b0;
    t_basis();
    t_known();
    t_sweep();
    t_inverse();
    t_comb();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule